// File: doc/BRIEF.md
# Absent Secondary Disk Channel Responder

This block stands in for a legacy disk channel that the chip does not build. Old software probes the channel's I/O addresses and may wait on them. The block watches the I/O request stream and claims any cycle aimed at the channel's command block (addresses 170h to 177h) or its control port (376h). On a claimed read it returns a zero byte. On a claimed write it accepts the data and drops it. As a result, software sees an empty channel and does not stall.

A 16-bit timing register is reached through a plain configuration write port with byte enables, and its value is always visible on a read-back bus.

- Bit 15 is the channel decode switch.
- Bit 11 is reserved.
- All other bits are plain storage that software may write and read back. They have no effect on the block.

Decoding also needs the chip-wide I/O space enable input. Two per-signal switch-off inputs can silence either address group while decode is on.

The request side is a valid/ready stream. `req_ready` is always high, so the block never applies back-pressure. A request counts as transferred in any cycle where `req_valid` is high. `req_addr`, `req_write` and `req_wdata` need only be stable while `req_valid` is high. The claim answer comes back in the same cycle as the request, with no register in between.

Top module: `stubide_sec_chan`

## Requirements
- R1: After reset the timing register reads 0000h on `cfg_rdata`.
- R2: A configuration write stores `cfg_wdata[7:0]` when `cfg_be[0]` is set and `cfg_wdata[15:8]` when `cfg_be[1]` is set. The new value appears on `cfg_rdata` after the clock edge, and a lane whose enable is clear keeps its old value.
- R3: Bit 11 of the timing register always reads 0, whatever is written to it.
- R4: No request is claimed unless both of these are 1: timing register bit 15 and `io_space_en`.
- R5: With decode active and `sig_off[0]`=0, a valid request to any address from 0170h to 0177h is claimed, for both reads and writes.
- R6: With decode active and `sig_off[1]`=0, a valid request to address 0376h is claimed.
- R7: A claimed read returns `io_rdata` = 00h.
- R8: A request to any address outside 0170h–0177h and 0376h is never claimed, so `io_claim` stays 0. This includes the neighbours 016Fh, 0178h, 0375h and 0377h.
- R9: `sig_off[0]`=1 suppresses claims of the command block only, and `sig_off[1]`=1 suppresses claims of 0376h only.
- R10: `io_claim` is high only in a cycle with `req_valid` high, and it rises in that same cycle. `req_ready` is always 1. A claimed write leaves the timing register unchanged.
- R11: Timing register bits 14:12 and 10:0 have no effect on which requests are claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_space_en | input | 1 | Chip-wide I/O space enable |
| sig_off | input | 2 | Bit 0 silences the command block, bit 1 silences the control port |
| cfg_wr | input | 1 | Timing register write strobe |
| cfg_be | input | 2 | Byte enables for the timing register write |
| cfg_wdata | input | 16 | Timing register write data |
| cfg_rdata | output | 16 | Timing register contents |
| req_valid | input | 1 | I/O request present |
| req_ready | output | 1 | Always 1; the block never applies back-pressure |
| req_addr | input | 16 | I/O request address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | 8 | Write data; dropped |
| io_claim | output | 1 | Request claimed in this cycle |
| io_rdata | output | 8 | Read data for a claimed read; always 00h |

## Verification
The bench probes both edges of the command block and the addresses just outside it, and both neighbours of 0376h. An off-by-one range compare would claim 016Fh or 0178h, or drop 0177h. It turns each enable on and off alone: a design that used OR instead of AND would claim with only one enable set, and a design with the switch-off bits crossed would silence the wrong group. It writes ones into bit 11 and into the no-op fields, and writes single byte lanes. A design that stored the reserved bit, ignored a byte enable, or decoded from the wrong bit would show a wrong read-back or a wrong claim. Finally it issues claimed writes and checks that the register did not absorb the data.

// File: rtl/stubide_pkg.sv
package stubide_pkg;
  localparam int unsigned TREG_W     = 16;
  localparam int unsigned DEC_EN_BIT = 15;
  localparam int unsigned RSVD_BIT   = 11;

  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_CMD  = 2'd1,
    HIT_CTL  = 2'd2
  } hit_e;
endpackage

// File: rtl/stubide_treg.sv
// Timing register with per-byte write enables and one read-as-zero bit.
module stubide_treg #(
  parameter int unsigned W    = 16,
  parameter int unsigned RSVD = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [W/8-1:0]   be,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     q
);
  localparam int unsigned LANES = W / 8;
  localparam logic [W-1:0] KEEP_MASK = ~({{(W-1){1'b0}}, 1'b1} << RSVD);

  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    for (int i = 0; i < LANES; i++) begin
      if (wr && be[i]) nxt[i*8 +: 8] = wdata[i*8 +: 8];
    end
    nxt = nxt & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/stubide_decode.sv
// Address match against the command block range and the control port.
module stubide_decode
  import stubide_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned CMD_BASE = 'h170,
  parameter int unsigned CMD_SPAN = 8,
  parameter int unsigned CTL_ADDR = 'h376
) (
  input  logic [AW-1:0] addr,
  input  logic          cmd_off,
  input  logic          ctl_off,
  output hit_e          hit
);
  localparam logic [AW-1:0] CMD_LO = AW'(CMD_BASE);
  localparam logic [AW-1:0] CMD_HI = AW'(CMD_BASE + CMD_SPAN - 1);
  localparam logic [AW-1:0] CTL_A  = AW'(CTL_ADDR);

  logic in_cmd, in_ctl;

  always_comb begin
    in_cmd = (addr >= CMD_LO) && (addr <= CMD_HI);
    in_ctl = (addr == CTL_A);
    if (in_cmd && !cmd_off)      hit = HIT_CMD;
    else if (in_ctl && !ctl_off) hit = HIT_CTL;
    else                         hit = HIT_NONE;
  end
endmodule

// File: rtl/stubide_sec_chan.sv
module stubide_sec_chan
  import stubide_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 8,
  parameter int unsigned CMD_BASE = 'h170,
  parameter int unsigned CMD_SPAN = 8,
  parameter int unsigned CTL_ADDR = 'h376
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_space_en,
  input  logic [1:0]        sig_off,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_be,
  input  logic [TREG_W-1:0] cfg_wdata,
  output logic [TREG_W-1:0] cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_write,
  input  logic [DW-1:0]     req_wdata,
  output logic              io_claim,
  output logic [DW-1:0]     io_rdata
);
  logic [TREG_W-1:0] treg_q;
  hit_e              hit;
  logic              dec_on;
  logic              unused_sink;

  stubide_treg #(.W(TREG_W), .RSVD(RSVD_BIT)) u_treg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .be    (cfg_be),
    .wdata (cfg_wdata),
    .q     (treg_q)
  );

  stubide_decode #(
    .AW(AW), .CMD_BASE(CMD_BASE), .CMD_SPAN(CMD_SPAN), .CTL_ADDR(CTL_ADDR)
  ) u_dec (
    .addr    (req_addr),
    .cmd_off (sig_off[0]),
    .ctl_off (sig_off[1]),
    .hit     (hit)
  );

  assign dec_on    = treg_q[DEC_EN_BIT] & io_space_en;
  assign io_claim  = req_valid & dec_on & (hit != HIT_NONE);
  assign req_ready = 1'b1;
  assign io_rdata  = '0;
  assign cfg_rdata = treg_q;
  // Write data and read/write direction carry no state: dropped on purpose.
  assign unused_sink = ^{req_wdata, req_write};
endmodule

// File: rtl/stubide_sec_chan_chk.sv
module stubide_sec_chan_chk #(
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 8,
  parameter int unsigned CMD_BASE = 'h170,
  parameter int unsigned CMD_SPAN = 8,
  parameter int unsigned CTL_ADDR = 'h376
) (
  input logic          clk,
  input logic          rst_n,
  input logic          io_space_en,
  input logic          cfg_wr,
  input logic [15:0]   cfg_rdata,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          req_write,
  input logic          io_claim,
  input logic [DW-1:0] io_rdata
);
  AST_CLAIM_NEEDS_BOTH_EN: assert property (@(posedge clk) disable iff (!rst_n)
    io_claim |-> (cfg_rdata[15] && io_space_en)); // R4
  AST_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (io_claim && !req_write) |-> (io_rdata == '0)); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[11] == 1'b0); // R3
  AST_CLAIM_IN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    io_claim |-> ((req_addr >= AW'(CMD_BASE) && req_addr <= AW'(CMD_BASE + CMD_SPAN - 1))
                  || req_addr == AW'(CTL_ADDR))); // R8
  AST_CLAIM_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    io_claim |-> (req_valid && req_ready)); // R10
  AST_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (io_claim && req_write && !cfg_wr) |=> $stable(cfg_rdata)); // R10
endmodule

bind stubide_sec_chan stubide_sec_chan_chk #(
  .AW(AW), .DW(DW), .CMD_BASE(CMD_BASE), .CMD_SPAN(CMD_SPAN), .CTL_ADDR(CTL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_space_en(io_space_en), .cfg_wr(cfg_wr),
  .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_write(req_write), .io_claim(io_claim),
  .io_rdata(io_rdata)
);

// File: tb/tb_stubide_sec_chan.sv
module tb_stubide_sec_chan;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_space_en = 1'b0;
  logic [1:0]  sig_off = 2'b00;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_be = 2'b00;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        io_claim;
  logic [7:0]  io_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [15:0] exp_reg = '0;

  typedef struct packed { logic claim; logic rd; logic [15:0] addr; } exp_t;
  exp_t sbq[$];
  string tagq[$];

  always #(CLK_P/2) clk = ~clk;

  stubide_sec_chan dut (
    .clk(clk), .rst_n(rst_n), .io_space_en(io_space_en), .sig_off(sig_off),
    .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .io_claim(io_claim), .io_rdata(io_rdata)
  );

  function automatic logic model_claim(logic [15:0] a);
    logic in_cmd, in_ctl;
    in_cmd = (a >= 16'h0170) && (a <= 16'h0177) && !sig_off[0];
    in_ctl = (a == 16'h0376) && !sig_off[1];
    return exp_reg[15] && io_space_en && (in_cmd || in_ctl);
  endfunction

  // Driver: present one request for one cycle, push the expectation.
  task automatic io_cycle(input logic [15:0] a, input logic wr, input string tag);
    exp_t e;
    @(negedge clk);
    e.claim = model_claim(a); e.rd = !wr; e.addr = a;
    sbq.push_back(e); tagq.push_back(tag);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = 8'h5A ^ a[7:0];
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cfg_write(input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 2'b00;
    if (be[0]) exp_reg[7:0]  = d[7:0];
    if (be[1]) exp_reg[15:8] = d[15:8];
    exp_reg[11] = 1'b0;
  endtask

  task automatic check_reg(input string tag);
    #1;
    checks++;
    if (cfg_rdata !== exp_reg) begin
      errors++;
      $display("FAIL %s: cfg_rdata=%h expected %h", tag, cfg_rdata, exp_reg);
    end
  endtask

  // Monitor: compare outputs against the scoreboard while a request is up.
  always @(negedge clk) begin
    #1;
    if (req_valid && sbq.size() > 0) begin
      exp_t e;
      string t;
      e = sbq.pop_front(); t = tagq.pop_front();
      checks++;
      if (io_claim !== e.claim || req_ready !== 1'b1) begin
        errors++;
        $display("FAIL %s: addr=%h claim=%b ready=%b expected claim=%b ready=1",
                 t, e.addr, io_claim, req_ready, e.claim);
      end
      if (e.claim && e.rd) begin
        checks++;
        if (io_rdata !== 8'h00) begin
          errors++;
          $display("FAIL R7: addr=%h rdata=%h expected 00", e.addr, io_rdata);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_reg("R1 reset value");

    io_space_en = 1'b1;
    io_cycle(16'h0170, 1'b0, "R4 decode bit clear");
    cfg_write(16'h8000, 2'b11);
    check_reg("R2 set decode bit");
    io_space_en = 1'b0;
    io_cycle(16'h0170, 1'b0, "R4 io space off");
    io_cycle(16'h0376, 1'b0, "R4 io space off ctl");
    io_space_en = 1'b1;

    for (int a = 'h170; a <= 'h177; a++) io_cycle(16'(a), 1'b0, "R5 cmd read");
    for (int a = 'h170; a <= 'h177; a++) io_cycle(16'(a), 1'b1, "R5 cmd write");
    check_reg("R10 claimed writes dropped");
    io_cycle(16'h0376, 1'b0, "R6 ctl read");
    io_cycle(16'h0376, 1'b1, "R6 ctl write");
    check_reg("R10 ctl write dropped");

    io_cycle(16'h016F, 1'b0, "R8 below cmd");
    io_cycle(16'h0178, 1'b0, "R8 above cmd");
    io_cycle(16'h0375, 1'b0, "R8 below ctl");
    io_cycle(16'h0377, 1'b1, "R8 above ctl");
    io_cycle(16'h01F0, 1'b0, "R8 other channel");
    io_cycle(16'h0000, 1'b1, "R8 zero addr");

    sig_off = 2'b01;
    io_cycle(16'h0173, 1'b0, "R9 cmd silenced");
    io_cycle(16'h0376, 1'b0, "R9 ctl still on");
    sig_off = 2'b10;
    io_cycle(16'h0173, 1'b0, "R9 cmd still on");
    io_cycle(16'h0376, 1'b0, "R9 ctl silenced");
    sig_off = 2'b00;

    cfg_write(16'hFFFF, 2'b11);
    check_reg("R3 reserved bit stays zero");
    io_cycle(16'h0174, 1'b0, "R11 noop fields set");
    cfg_write(16'h1234, 2'b01);
    check_reg("R2 low lane only");
    cfg_write(16'h0800, 2'b10);
    check_reg("R3 high lane reserved write");
    io_cycle(16'h0174, 1'b0, "R4 decode cleared by lane write");
    cfg_write(16'hA5A5, 2'b11);
    check_reg("R2 full write");
    io_cycle(16'h0177, 1'b0, "R11 other noop pattern");
    io_cycle(16'h0376, 1'b1, "R11 ctl with noop pattern");

    // R10: no claim while req_valid is low, even on a mapped address.
    @(negedge clk);
    req_addr = 16'h0171; req_write = 1'b0;
    #1;
    checks++;
    if (io_claim !== 1'b0 || req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R10: idle claim=%b ready=%b expected claim=0 ready=1", io_claim, req_ready);
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule